// File: doc/BRIEF.md
# Threshold-Based Energy Pulse Accumulator

This block turns a stream of signed per-sample power values into three watt-hour style energy counters, one for each phase channel. Each channel owns a hidden fine accumulator that is wider than the threshold. Every valid sample is added into it. When the running sum reaches the positive threshold, the energy counter steps up by one and the threshold is taken back out of the fine sum. When the sum reaches the negative threshold, the counter steps down by one and the threshold is added back in. A single threshold is shared by all channels, so the threshold sets how much energy one count of a counter represents.

The energy counters wrap silently at their signed limits. A half-full event occurs when a step flips the second-highest bit of any counter. That event latches a status flag. The flag pulls an active-low interrupt low when its mask bit is set, and software clears it by writing a one to it. A mode bit turns every energy read into a read-and-zero.

Software reaches the block through a simple register port. Writes take effect at the clock edge. Read data appears on `reg_rdata_o` one cycle after `reg_re_i`. Power samples come in on a valid strobe, nominally once every 125 µs.

Top module: `energy_pulse_accum`

## Requirements
- R1: The 48-bit threshold is written as two words. Address 0x0 loads threshold bits 23:0 from write data bits 23:0. Address 0x1 loads threshold bits 46:24 from write data bits 22:0. Threshold bit 47 is always zero, so write data bit 23 at address 0x1 is ignored. Reading either address returns its 24-bit field with bits 31:24 zero.
- R2: On each cycle with `smp_vld_i` high, every channel adds its sample to its fine accumulator. If the sum is at least +threshold, the energy count rises by 1 and the accumulator keeps the sum minus the threshold. Otherwise, if the sum is at most −threshold, the count falls by 1 and the accumulator keeps the sum plus the threshold. Otherwise the sum is kept and the count is unchanged. At most one step happens per sample.
- R3: A stored threshold of zero behaves as a threshold of one.
- R4: Energy counts are two's complement of width EW (32 by default). Stepping up from the largest positive value gives the most negative value, and stepping down from the most negative value gives the largest positive value.
- R5: Status bit 0 (address 0x2) is set when a step changes bit EW−2 of any energy count (bit 30 at the default width). This holds for both step directions.
- R6: Writing 1 to status bit 0 clears it, and writing 0 has no effect. If a clearing write and a setting step fall in the same cycle, the bit ends up set.
- R7: `irq_no` is low exactly when status bit 0 and mask bit 0 (address 0x3) are both set. Otherwise it is high.
- R8: Mode bit 6 (address 0x4) enables read-with-clear. With it set, reading energy address 0x8+ch returns the count and then zeroes it. With it clear, reads leave the count unchanged.
- R9: If a clearing read of a channel falls in the same cycle as a step of that channel, the read returns the pre-step count and the channel is left holding +1 or −1 (the step direction).
- R10: After reset, all registers read zero (threshold, status, mask, mode, energies) and `irq_no` is high.
- R11: Channels are independent. A sample on one channel never changes another channel's count.
- R12: With the threshold at 0x1FF6A6B, a sample equal to 0x1FF6A6B gives exactly one up-step per sample, and a smaller sample gives none.
- R13: Energy reads return the count sign-extended to 32 bits. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Power samples valid this cycle |
| pwr_i | input | NCH*PW | Signed power sample per channel, channel 0 in the low bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data, valid the cycle after the read strobe |
| irq_no | output | 1 | Active-low half-full interrupt |

## Verification
Two pairs of functions can land on the same clock edge, and each pair is provoked on purpose.

The first pair is a clearing energy read and a sample that steps the same channel. The bench raises `reg_re_i` and `smp_vld_i` in one cycle. It then checks that the returned word is the count from before the step, and that the next read gives exactly +1 or −1.

The second pair is a write-one-to-clear of the status bit and a step that crosses the half-full bit. The bench drives both in one cycle and then expects the status bit to still be set.

// File: rtl/epa_pkg.sv
package epa_pkg;
  localparam int A_THR_LO   = 0;
  localparam int A_THR_HI   = 1;
  localparam int A_STATUS   = 2;
  localparam int A_MASK     = 3;
  localparam int A_MODE     = 4;
  localparam int A_ENERGY   = 8;
  localparam int MODE_RCLR  = 6;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/epa_chan.sv
module epa_chan
  import epa_pkg::*;
#(
  parameter int PW    = 32,
  parameter int THR_W = 48,
  parameter int ACC_W = 50,
  parameter int EW    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [PW-1:0] pwr_i,
  input  logic [THR_W-1:0]     thr_i,
  input  logic                 clr_i,
  output logic [EW-1:0]        energy_o,
  output logic                 hf_evt_o
);
  localparam logic [EW-1:0] E_MAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] E_MIN = {1'b1, {(EW-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_sum, acc_nxt, thr_s, pwr_ext;
  logic [EW-1:0] energy_q, e_up, e_dn, e_step;
  step_e step;

  assign pwr_ext = ACC_W'(pwr_i);
  assign thr_s   = signed'({{(ACC_W-THR_W){1'b0}}, thr_i});
  assign acc_sum = acc_q + pwr_ext;
  assign e_up    = energy_q + EW'(1);
  assign e_dn    = energy_q - EW'(1);

  always_comb begin
    step    = STEP_NONE;
    acc_nxt = acc_sum;
    e_step  = energy_q;
    if (acc_sum >= thr_s) begin
      step    = STEP_UP;
      acc_nxt = acc_sum - thr_s;
      e_step  = e_up;
    end else if (acc_sum <= -thr_s) begin
      step    = STEP_DN;
      acc_nxt = acc_sum + thr_s;
      e_step  = e_dn;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      energy_q <= '0;
    end else begin
      if (vld_i) acc_q <= acc_nxt;
      if (clr_i) begin
        // step from a colliding sample survives the clear
        if (vld_i && step == STEP_UP)      energy_q <= EW'(1);
        else if (vld_i && step == STEP_DN) energy_q <= '1;
        else                               energy_q <= '0;
      end else if (vld_i) begin
        energy_q <= e_step;
      end
    end
  end

  assign hf_evt_o = vld_i && (step != STEP_NONE) && (e_step[EW-2] != energy_q[EW-2]);
  assign energy_o = energy_q;

  p_one_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (energy_q == $past(energy_q) || energy_q == $past(energy_q) + EW'(1)
                || energy_q == $past(energy_q) - EW'(1)));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(energy_q));
  p_wrap_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && step == STEP_UP && energy_q == E_MAX) |=> energy_q == E_MIN);
  p_wrap_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && step == STEP_DN && energy_q == E_MIN) |=> energy_q == E_MAX);
  p_clr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !vld_i) |=> energy_q == '0);
  p_collide_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && vld_i && step == STEP_UP) |=> energy_q == EW'(1));
endmodule

// File: rtl/epa_csr.sv
module epa_csr
  import epa_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int THR_W = 48,
  parameter int EW    = 32,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    hf_evt_i,
  input  logic [NCH-1:0][EW-1:0]  energy_i,
  output logic [DW-1:0]           rdata_o,
  output logic [THR_W-1:0]        thr_eff_o,
  output logic [NCH-1:0]          clr_o,
  output logic                    irq_no
);
  localparam int HALF = THR_W / 2;

  logic [THR_W-1:0] thr_q;
  logic status_q, mask_q, rclr_q;
  logic [DW-1:0] rdata_q, rd_mux;
  logic wr_lo, wr_hi, wr_stat, wr_mask, wr_mode;
  logic unused_wdata;

  assign wr_lo   = we_i && addr_i == AW'(A_THR_LO);
  assign wr_hi   = we_i && addr_i == AW'(A_THR_HI);
  assign wr_stat = we_i && addr_i == AW'(A_STATUS);
  assign wr_mask = we_i && addr_i == AW'(A_MASK);
  assign wr_mode = we_i && addr_i == AW'(A_MODE);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q    <= '0;
      status_q <= 1'b0;
      mask_q   <= 1'b0;
      rclr_q   <= 1'b0;
    end else begin
      if (wr_lo) thr_q[HALF-1:0]     <= wdata_i[HALF-1:0];
      if (wr_hi) thr_q[THR_W-1:HALF] <= {1'b0, wdata_i[HALF-2:0]};
      if (wr_mask) mask_q <= wdata_i[0];
      if (wr_mode) rclr_q <= wdata_i[MODE_RCLR];
      // set beats clear
      if (hf_evt_i)                    status_q <= 1'b1;
      else if (wr_stat && wdata_i[0])  status_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      AW'(A_THR_LO): rd_mux = DW'(thr_q[HALF-1:0]);
      AW'(A_THR_HI): rd_mux = DW'(thr_q[THR_W-1:HALF]);
      AW'(A_STATUS): rd_mux = DW'(status_q);
      AW'(A_MASK):   rd_mux = DW'(mask_q);
      AW'(A_MODE):   rd_mux = DW'(rclr_q) << MODE_RCLR;
      default: begin
        for (int ch = 0; ch < NCH; ch++)
          if (addr_i == AW'(A_ENERGY + ch)) rd_mux = DW'($signed(energy_i[ch]));
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_clr
    assign clr_o[g] = re_i && rclr_q && addr_i == AW'(A_ENERGY + g);
  end

  assign thr_eff_o = (thr_q == '0) ? THR_W'(1) : thr_q;
  assign rdata_o   = rdata_q;
  assign irq_no    = !(status_q && mask_q);

  p_hf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_evt_i |=> status_q);
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && !hf_evt_i) |=> !status_q);
  p_irq_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hf_evt_i && mask_q && !wr_mask) |=> !irq_no);
  p_thr_sign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> !thr_q[THR_W-1]);
endmodule

// File: rtl/energy_pulse_accum.sv
module energy_pulse_accum
  import epa_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int PW    = 32,
  parameter int THR_W = 48,
  parameter int EW    = 32,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic [NCH-1:0][PW-1:0]  pwr_i,
  input  logic                    reg_we_i,
  input  logic                    reg_re_i,
  input  logic [AW-1:0]           reg_addr_i,
  input  logic [DW-1:0]           reg_wdata_i,
  output logic [DW-1:0]           reg_rdata_o,
  output logic                    irq_no
);
  localparam int ACC_W = THR_W + 2;

  logic [THR_W-1:0]        thr_eff;
  logic [NCH-1:0]          clr;
  logic [NCH-1:0]          hf_evt;
  logic [NCH-1:0][EW-1:0]  energy;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    epa_chan #(
      .PW(PW), .THR_W(THR_W), .ACC_W(ACC_W), .EW(EW)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (smp_vld_i),
      .pwr_i    (pwr_i[g]),
      .thr_i    (thr_eff),
      .clr_i    (clr[g]),
      .energy_o (energy[g]),
      .hf_evt_o (hf_evt[g])
    );
  end

  epa_csr #(
    .NCH(NCH), .THR_W(THR_W), .EW(EW), .DW(DW), .AW(AW)
  ) u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .re_i      (reg_re_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hf_evt_i  (|hf_evt),
    .energy_i  (energy),
    .rdata_o   (reg_rdata_o),
    .thr_eff_o (thr_eff),
    .clr_o     (clr),
    .irq_no    (irq_no)
  );

  p_clr_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));
endmodule

// File: tb/energy_pulse_accum_tb.sv
module energy_pulse_accum_tb;
  localparam int EW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [2:0][31:0] pwr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_n;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  energy_pulse_accum #(.EW(EW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .pwr_i(pwr),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; vld = 1'b0; we = 1'b0; re = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic smp(input int a, input int b, input int c);
    @(negedge clk); vld = 1'b1; pwr[0] = 32'(a); pwr[1] = 32'(b); pwr[2] = 32'(c);
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R10 irq", 32'(irq_n), 32'h1);
    for (int a = 0; a < 5; a++) begin rd(4'(a), d); chk("R10 reg", d, 0); end
    for (int a = 8; a < 11; a++) begin rd(4'(a), d); chk("R10 energy", d, 0); end
    rd(4'd15, d); chk("R13 unmapped", d, 0);
  endtask

  task automatic t_thr();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 32'hFFAB_CDEF); rd(4'd0, d); chk("R1 lo", d, 32'h00AB_CDEF);
    wr(4'd1, 32'h00FF_FFFF); rd(4'd1, d); chk("R1 hi sign", d, 32'h007F_FFFF);
  endtask

  task automatic t_zero_thr();
    logic [31:0] d;
    do_reset();
    smp(0, 0, 0); rd(4'd8, d); chk("R3 zero sample", d, 0);
    smp(1, 0, 0); rd(4'd8, d); chk("R3 unit step", d, 1);
    smp(5, 0, 0); rd(4'd8, d); chk("R2 single step", d, 2);
  endtask

  task automatic t_step();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 10);
    smp(4, 0, 0); smp(4, 0, 0); rd(4'd8, d); chk("R2 below thr", d, 0);
    smp(4, 0, 0); rd(4'd8, d); chk("R2 up", d, 1);
    smp(-5, 0, 0); rd(4'd8, d); chk("R2 hold", d, 1);
    smp(-7, 0, 0); rd(4'd8, d); chk("R2 down", d, 0);
    smp(-10, 0, 0); rd(4'd8, d); chk("R2 neg R13 sext", d, 32'hFFFF_FFFF);
    smp(35, 0, 0); rd(4'd8, d); chk("R2 big one step", d, 0);
    smp(0, 0, 0); rd(4'd8, d); chk("R2 residue a", d, 1);
    smp(0, 0, 0); rd(4'd8, d); chk("R2 residue b", d, 2);
    smp(0, 0, 0); rd(4'd8, d); chk("R2 residue done", d, 2);
  endtask

  task automatic t_chan();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 1);
    for (int i = 0; i < 3; i++) smp(1, 0, -1);
    rd(4'd8, d);  chk("R11 ch0", d, 3);
    rd(4'd9, d);  chk("R11 ch1", d, 0);
    rd(4'd10, d); chk("R11 ch2", d, 32'hFFFF_FFFD);
  endtask

  task automatic t_pmax();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 32'h00FF_6A6B); wr(4'd1, 32'h1);
    for (int i = 0; i < 5; i++) smp(0, 32'h1FF6A6B, 0);
    rd(4'd9, d); chk("R12 per sample", d, 5);
    rd(4'd8, d); chk("R11 ch0 idle", d, 0);
    smp(0, 32'h1FF6A6A, 0); rd(4'd9, d); chk("R12 below", d, 5);
    smp(0, 1, 0); rd(4'd9, d); chk("R12 accumulate", d, 6);
  endtask

  task automatic t_half_wrap();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 1); wr(4'd3, 1);
    for (int i = 0; i < 255; i++) smp(1, 0, 0);
    rd(4'd2, d); chk("R5 not yet", d, 0);
    chk("R7 irq idle", 32'(irq_n), 1);
    smp(1, 0, 0);
    rd(4'd2, d); chk("R5 up crossing", d, 1);
    chk("R7 irq low", 32'(irq_n), 0);
    wr(4'd2, 0); rd(4'd2, d); chk("R6 write zero", d, 1);
    wr(4'd2, 1); rd(4'd2, d); chk("R6 w1c", d, 0);
    chk("R7 irq released", 32'(irq_n), 1);
    for (int i = 0; i < 255; i++) smp(1, 0, 0);
    rd(4'd8, d); chk("R4 max", d, 32'h0000_01FF);
    smp(1, 0, 0); rd(4'd8, d); chk("R4 wrap up", d, 32'hFFFF_FE00);
    smp(-1, 0, 0); rd(4'd8, d); chk("R4 wrap down", d, 32'h0000_01FF);
  endtask

  task automatic t_down();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 1);
    smp(-1, 0, 0);
    rd(4'd2, d); chk("R5 down flip", d, 1);
    chk("R7 masked", 32'(irq_n), 1);
    wr(4'd2, 1);
    for (int i = 0; i < 255; i++) smp(-1, 0, 0);
    rd(4'd2, d); chk("R5 no flip", d, 0);
    // clear and crossing in one cycle
    @(negedge clk); we = 1'b1; addr = 4'd2; wdata = 1; vld = 1'b1; pwr[0] = 32'hFFFF_FFFF;
    @(negedge clk); we = 1'b0; vld = 1'b0;
    rd(4'd2, d); chk("R6 set wins", d, 1);
    rd(4'd8, d); chk("R5 value", d, 32'hFFFF_FEFF);
  endtask

  task automatic t_clr();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 1);
    for (int i = 0; i < 3; i++) smp(0, 0, 1);
    rd(4'd10, d); chk("R8 plain read", d, 3);
    rd(4'd10, d); chk("R8 no clear", d, 3);
    wr(4'd4, 32'h40); rd(4'd4, d); chk("R8 mode rb", d, 32'h40);
    rd(4'd10, d); chk("R8 clr read", d, 3);
    rd(4'd10, d); chk("R8 cleared", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    do_reset();
    wr(4'd0, 1); wr(4'd4, 32'h40);
    smp(1, 0, 0); smp(1, 0, 0);
    @(negedge clk); re = 1'b1; addr = 4'd8; vld = 1'b1; pwr[0] = 1;
    @(negedge clk); re = 1'b0; vld = 1'b0; d = rdata;
    chk("R9 pre value", d, 2);
    rd(4'd8, d); chk("R9 step kept", d, 1);
    @(negedge clk); re = 1'b1; addr = 4'd8; vld = 1'b1; pwr[0] = 32'hFFFF_FFFF;
    @(negedge clk); re = 1'b0; vld = 1'b0; d = rdata;
    chk("R9 pre zero", d, 0);
    rd(4'd8, d); chk("R9 down kept", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_thr();
    t_zero_thr();
    t_step();
    t_chan();
    t_pmax();
    t_half_wrap();
    t_down();
    t_clr();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule